// File: doc/BRIEF.md
# Bipolar Line Code Decoder

This block turns a dual-rail bipolar receive stream into one NRZ bit per line clock. Each clock it samples a positive-pulse rail and a negative-pulse rail. It tracks the polarity of the most recent mark, and it spots bipolar violations: a mark on the same rail as the mark before it. It then removes the zero-substitution groups that the selected line code inserts. Three codes are available: plain alternate mark inversion (AMI), three-zero substitution (B3ZS), and four-zero substitution (HDB3). A bypass setting sends the positive rail straight to the output.

The decoded bits pass through a short window of registered slots. A substitution group ends in a violation, and the fill pulse at the start of the group reaches the block before that violation does. The window holds the fill pulse until the violation confirms it, then clears it. The output is tapped at a fixed depth for each code, so latency is constant within a mode.

The window's logic is built around a polarity state machine with three states. `POL_NONE` means no mark has been seen since reset, since an illegal symbol, or while in bypass. `POL_POS` means the last mark was on the positive rail, and `POL_NEG` means it was on the negative rail. The transitions are named as follows:
- `T_TO_NONE`: bypass is active, or both rails are high.
- `T_MARK_POS`: a single mark arrives on the positive rail.
- `T_MARK_NEG`: a single mark arrives on the negative rail.
- `T_HOLD`: a space arrives, and the state does not change.

A configuration register holds the active code and the bypass setting. It loads them in a reset cycle, or in a cycle where the window is empty.

Top module: `bipolar_decoder`

## Requirements
- R1: A synchronous reset clears all three outputs to 0 by the clock after the reset edge. It also clears the last-mark polarity, so the first mark after reset is never flagged as a violation.
- R2: Codes 2'b00 and 2'b11 on `mode_sel` select AMI. In AMI, a mark on exactly one rail decodes to 1 and a space (both rails low) decodes to 0. A symbol sampled at edge k is presented after edge k.
- R3: In AMI, a mark on the same rail as the previous mark still decodes to 1. It raises `bpv_out` and `code_err` together with that bit.
- R4: Code 2'b01 selects B3ZS, with the output presented two edges after the symbol's own edge. A violation whose preceding slot is a space is treated as a 00V or B0V group. The violation and the slot two positions before it both decode to 0, and `bpv_out` rises with the violation's slot.
- R5: Code 2'b10 selects HDB3, with the output presented three edges after the symbol's own edge. A violation preceded by two spaces is treated as a 000V or B00V group. The violation and the slot three positions before it both decode to 0, and `bpv_out` rises with the violation's slot.
- R6: A substitution group is removed even when it is the variant that the alternation rule does not expect at that point, for example two 000V groups in a row.
- R7: In B3ZS or HDB3, a violation that does not fit the group shape decodes to 1 and raises both `bpv_out` and `code_err`.
- R8: Both rails high in the same clock decodes to 1 and raises `code_err` but not `bpv_out`. It also resets the last-mark polarity to none.
- R9: With bypass active, the output equals the positive rail with a latency of one edge. The negative rail is ignored, and both flags stay low.
- R10: A new code or bypass setting takes effect only at a reset edge, or at an edge where every window slot is empty and the incoming symbol decodes to an empty slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line clock, one symbol per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Code select: 00/11 AMI, 01 B3ZS, 10 HDB3 |
| bypass | input | 1 | Pass the positive rail through as NRZ |
| pos_in | input | 1 | Positive pulse rail |
| neg_in | input | 1 | Negative pulse rail |
| nrz_out | output | 1 | Decoded NRZ bit |
| bpv_out | output | 1 | Bipolar violation seen at this bit position |
| code_err | output | 1 | Unmatched violation or illegal symbol at this bit position |

## Verification
A symbol driven before edge k shows up at the outputs after a fixed number of edges:
- after edge k in AMI and in bypass;
- after edge k+2 in B3ZS;
- after edge k+3 in HDB3.

The bench drives each symbol half a period before its edge and samples every output half a period after each edge. It lines the recorded stream up with the symbol stream by that per-mode offset. The configuration test samples one edge after a mid-stream mode change, to show the old code still applies. It then waits well past the window flush before applying the new code.

// File: rtl/bpd_pkg.sv
`timescale 1ns/1ps
package bpd_pkg;

    typedef enum logic [1:0] {
        CODE_AMI     = 2'b00,
        CODE_B3ZS    = 2'b01,
        CODE_HDB3    = 2'b10,
        CODE_AMI_ALT = 2'b11
    } line_code_e;

    typedef enum logic [1:0] {
        POL_NONE = 2'b00,
        POL_POS  = 2'b01,
        POL_NEG  = 2'b10
    } pol_state_e;

    typedef struct packed {
        logic dat;
        logic bpv;
        logic cerr;
    } slot_t;

    typedef struct packed {
        logic       byp;
        line_code_e code;
    } cfg_t;

endpackage

// File: rtl/bpd_polarity_fsm.sv
`timescale 1ns/1ps
module bpd_polarity_fsm
    import bpd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hold_none,
    input  logic pos_i,
    input  logic neg_i,
    output logic is_mark,
    output logic is_viol,
    output logic is_illegal
);

    pol_state_e st_q;
    pol_state_e st_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= POL_NONE;
        end else begin
            st_d_apply: st_q <= st_d;
        end
    end

    // next state: T_TO_NONE, T_MARK_POS, T_MARK_NEG, T_HOLD
    always_comb begin
        st_d = st_q;
        if (hold_none || (pos_i && neg_i)) begin
            st_d = POL_NONE;
        end else if (pos_i) begin
            st_d = POL_POS;
        end else if (neg_i) begin
            st_d = POL_NEG;
        end
    end

    // outputs: symbol classification against the stored polarity
    always_comb begin
        is_illegal = pos_i & neg_i & ~hold_none;
        is_mark    = (pos_i ^ neg_i) & ~hold_none;
        is_viol    = 1'b0;
        unique case (st_q)
            POL_NONE: is_viol = 1'b0;
            POL_POS:  is_viol = is_mark & pos_i;
            POL_NEG:  is_viol = is_mark & neg_i;
            default:  is_viol = 1'b0;
        endcase
    end

endmodule

// File: rtl/bpd_subst_window.sv
`timescale 1ns/1ps
module bpd_subst_window
    import bpd_pkg::*;
#(
    parameter int B3_LEN   = 3,
    parameter int HDB3_LEN = 4,
    parameter int WIN      = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  cfg_t  cfg,
    input  logic  pos_i,
    input  logic  is_mark,
    input  logic  is_viol,
    input  logic  is_illegal,
    output slot_t tap_o,
    output logic  idle_o
);

    localparam int B3_FILL = B3_LEN - 2;
    localparam int HD_FILL = HDB3_LEN - 2;
    localparam logic [WIN-1:0] B3_ZMASK = WIN'((1 << B3_FILL) - 1);
    localparam logic [WIN-1:0] HD_ZMASK = WIN'((1 << HD_FILL) - 1);

    slot_t [WIN-1:0] sr_q;
    slot_t [WIN-1:0] sr_d;
    slot_t           new_slot;
    logic  [WIN-1:0] dat_vec;
    logic  [WIN-1:0] busy_vec;
    logic  [WIN-1:0] clr_vec;
    logic            b3_ok;
    logic            hd_ok;
    logic            sub_hit;

    for (genvar i = 0; i < WIN; i++) begin : g_view
        assign dat_vec[i]  = sr_q[i].dat;
        assign busy_vec[i] = |sr_q[i];
    end

    assign b3_ok = ~|(dat_vec & B3_ZMASK);
    assign hd_ok = ~|(dat_vec & HD_ZMASK);

    // build the incoming slot and decide on substitution removal
    always_comb begin
        new_slot = '0;
        sub_hit  = 1'b0;
        clr_vec  = '0;
        if (cfg.byp) begin
            new_slot.dat = pos_i;
        end else if (is_illegal) begin
            new_slot.dat  = 1'b1;
            new_slot.cerr = 1'b1;
        end else if (is_viol) begin
            new_slot.bpv = 1'b1;
            unique case (cfg.code)
                CODE_B3ZS: begin
                    sub_hit = b3_ok;
                    if (b3_ok) clr_vec = WIN'(1) << B3_FILL;
                end
                CODE_HDB3: begin
                    sub_hit = hd_ok;
                    if (hd_ok) clr_vec = WIN'(1) << HD_FILL;
                end
                CODE_AMI, CODE_AMI_ALT: sub_hit = 1'b0;
                default:                sub_hit = 1'b0;
            endcase
            if (!sub_hit) begin
                new_slot.dat  = 1'b1;
                new_slot.cerr = 1'b1;
            end
        end else if (is_mark) begin
            new_slot.dat = 1'b1;
        end
    end

    // shift with fill clearing
    always_comb begin
        sr_d[0] = new_slot;
        for (int i = 1; i < WIN; i++) begin
            sr_d[i] = sr_q[i-1];
            if (clr_vec[i-1]) begin
                sr_d[i].dat  = 1'b0;
                sr_d[i].cerr = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    // output tap per code
    always_comb begin
        tap_o = sr_q[0];
        if (!cfg.byp) begin
            unique case (cfg.code)
                CODE_B3ZS:              tap_o = sr_q[B3_LEN-1];
                CODE_HDB3:              tap_o = sr_q[HDB3_LEN-1];
                CODE_AMI, CODE_AMI_ALT: tap_o = sr_q[0];
                default:                tap_o = sr_q[0];
            endcase
        end
    end

    assign idle_o = ~|busy_vec & ~|new_slot;

endmodule

// File: rtl/bipolar_decoder.sv
`timescale 1ns/1ps
module bipolar_decoder
    import bpd_pkg::*;
#(
    parameter int B3_LEN   = 3,
    parameter int HDB3_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_sel,
    input  logic       bypass,
    input  logic       pos_in,
    input  logic       neg_in,
    output logic       nrz_out,
    output logic       bpv_out,
    output logic       code_err
);

    localparam int WIN = (HDB3_LEN > B3_LEN) ? HDB3_LEN : B3_LEN;

    cfg_t       cfg_q;
    logic       is_mark;
    logic       is_viol;
    logic       is_illegal;
    logic       win_idle;
    slot_t      tap;
    logic       act_byp;
    logic [1:0] act_code;

    // configuration register: loads at reset or on an empty window
    always_ff @(posedge clk) begin
        if (rst || win_idle) begin
            cfg_q <= '{byp: bypass, code: line_code_e'(mode_sel)};
        end
    end

    assign act_byp  = cfg_q.byp;
    assign act_code = cfg_q.code;

    bpd_polarity_fsm i_fsm (
        .clk        (clk),
        .rst        (rst),
        .hold_none  (cfg_q.byp),
        .pos_i      (pos_in),
        .neg_i      (neg_in),
        .is_mark    (is_mark),
        .is_viol    (is_viol),
        .is_illegal (is_illegal)
    );

    bpd_subst_window #(
        .B3_LEN   (B3_LEN),
        .HDB3_LEN (HDB3_LEN),
        .WIN      (WIN)
    ) i_win (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg_q),
        .pos_i      (pos_in),
        .is_mark    (is_mark),
        .is_viol    (is_viol),
        .is_illegal (is_illegal),
        .tap_o      (tap),
        .idle_o     (win_idle)
    );

    assign nrz_out  = tap.dat;
    assign bpv_out  = tap.bpv;
    assign code_err = tap.cerr;

endmodule

// File: rtl/bipolar_decoder_chk.sv
`timescale 1ns/1ps
module bipolar_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       pos_in,
    input logic       neg_in,
    input logic       nrz_out,
    input logic       bpv_out,
    input logic       code_err,
    input logic       cfg_byp,
    input logic [1:0] cfg_code
);

    logic ami_on;
    assign ami_on = !cfg_byp && (cfg_code == 2'b00 || cfg_code == 2'b11);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!nrz_out && !bpv_out && !code_err)); // R1

    AST_AMI_MARK_ONE: assert property (@(posedge clk) disable iff (rst)
        (ami_on && (pos_in ^ neg_in)) |=> (nrz_out || !$stable(cfg_code) || !$stable(cfg_byp))); // R2

    AST_AMI_SPACE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ami_on && !pos_in && !neg_in) |=> (!nrz_out || !$stable(cfg_code) || !$stable(cfg_byp))); // R2

    AST_REMOVED_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bpv_out && !code_err) |-> !nrz_out); // R5

    AST_ERR_IS_ONE: assert property (@(posedge clk) disable iff (rst)
        code_err |-> nrz_out); // R7

    AST_ILLEGAL_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (ami_on && pos_in && neg_in) |=> ((code_err && !bpv_out) || !$stable(cfg_code) || !$stable(cfg_byp))); // R8

    AST_BYPASS_CLEAN: assert property (@(posedge clk) disable iff (rst)
        cfg_byp |-> (!bpv_out && !code_err)); // R9

    AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (cfg_byp && pos_in) |=> (nrz_out || !$stable(cfg_byp))); // R9

endmodule

bind bipolar_decoder bipolar_decoder_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .pos_in   (pos_in),
    .neg_in   (neg_in),
    .nrz_out  (nrz_out),
    .bpv_out  (bpv_out),
    .code_err (code_err),
    .cfg_byp  (act_byp),
    .cfg_code (act_code)
);

// File: tb/test_bipolar_decoder.sv
`timescale 1ns/1ps
module test_bipolar_decoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_sel = 2'b00;
    logic       bypass = 1'b0;
    logic       pos_in = 1'b0;
    logic       neg_in = 1'b0;
    logic       nrz_out;
    logic       bpv_out;
    logic       code_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic rec_d [64];
    logic rec_v [64];
    logic rec_e [64];

    always #5 clk = ~clk;

    bipolar_decoder i_bipolar_decoder (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .bypass   (bypass),
        .pos_in   (pos_in),
        .neg_in   (neg_in),
        .nrz_out  (nrz_out),
        .bpv_out  (bpv_out),
        .code_err (code_err)
    );

    task automatic check3(input string req, input string what,
                          input logic ad, input logic av, input logic ae,
                          input logic xd, input logic xv, input logic xe);
        checks++;
        if ({ad, av, ae} !== {xd, xv, xe}) begin
            errors++;
            $display("FAIL %s %s: got d/v/e=%b%b%b expected %b%b%b",
                     req, what, ad, av, ae, xd, xv, xe);
        end
    endtask

    task automatic drive_sym(input byte s);
        pos_in = (s == "+" || s == "X");
        neg_in = (s == "-" || s == "X");
    endtask

    // reset with a given configuration; ends half a period after the reset edge
    task automatic do_reset(input logic [1:0] m, input logic b);
        rst = 1'b1; mode_sel = m; bypass = b; pos_in = 1'b0; neg_in = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // drive a symbol string, record outputs each cycle, compare at offset lat-1
    task automatic run_case(input string req, input string sym,
                            input string xd, input string xv, input string xe,
                            input int lat);
        int n;
        n = sym.len();
        for (int c = 0; c < n + lat - 1; c++) begin
            if (c < n) drive_sym(sym[c]);
            else drive_sym("0");
            @(posedge clk);
            @(negedge clk);
            rec_d[c] = nrz_out;
            rec_v[c] = bpv_out;
            rec_e[c] = code_err;
        end
        drive_sym("0");
        for (int i = 0; i < n; i++) begin
            check3(req, $sformatf("%s slot %0d", sym, i),
                   rec_d[i+lat-1], rec_v[i+lat-1], rec_e[i+lat-1],
                   xd[i] == "1", xv[i] == "1", xe[i] == "1");
        end
    endtask

    task automatic t_reset_state();
        do_reset(2'b10, 1'b0);
        check3("R1", "outputs after reset", nrz_out, bpv_out, code_err, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_ami_basic();
        do_reset(2'b00, 1'b0);
        // R1 first mark negative, not a violation; R2 alternating marks
        run_case("R2", "-0+0-+0-", "10101101", "00000000", "00000000", 1);
    endtask

    task automatic t_ami_violation();
        do_reset(2'b00, 1'b0);
        run_case("R3", "+0+-", "1011", "0010", "0010", 1);
        do_reset(2'b11, 1'b0);
        run_case("R3", "++", "11", "01", "01", 1);
    endtask

    task automatic t_b3zs();
        do_reset(2'b01, 1'b0);
        run_case("R4", "+0-0-0+", "1000001", "0000100", "0000000", 3);
        do_reset(2'b01, 1'b0);
        run_case("R4", "+00+-", "10001", "00010", "00000", 3);
        do_reset(2'b01, 1'b0);
        run_case("R7", "+--0", "1110", "0010", "0010", 3);
    endtask

    task automatic t_hdb3();
        do_reset(2'b10, 1'b0);
        run_case("R5", "+-00-+", "100001", "000010", "000000", 4);
        do_reset(2'b10, 1'b0);
        run_case("R5", "+000+-", "100001", "000010", "000000", 4);
        do_reset(2'b10, 1'b0);
        run_case("R6", "+000+000+", "100000000", "000010001", "000000000", 4);
        do_reset(2'b10, 1'b0);
        run_case("R7", "+0++", "1011", "0011", "0011", 4);
    endtask

    task automatic t_illegal();
        do_reset(2'b00, 1'b0);
        run_case("R8", "+X+", "111", "000", "010", 1);
    endtask

    task automatic t_bypass();
        do_reset(2'b10, 1'b1);
        run_case("R9", "+-X0+", "10101", "00000", "00000", 1);
    endtask

    task automatic t_mode_change();
        do_reset(2'b00, 1'b0);
        drive_sym("+");
        @(posedge clk);
        @(negedge clk);
        mode_sel = 2'b10;
        drive_sym("+");
        @(posedge clk);
        @(negedge clk);
        // old AMI code still active: repeated mark is an unmatched violation
        check3("R10", "mode held while window busy", nrz_out, bpv_out, code_err, 1'b1, 1'b1, 1'b1);
        drive_sym("0");
        repeat (8) @(negedge clk);
        run_case("R10", "-000-", "10000", "00001", "00000", 4);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_ami_basic();
        t_ami_violation();
        t_b3zs();
        t_hdb3();
        t_illegal();
        t_bypass();
        t_mode_change();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule